// File: doc/BRIEF.md
# Line Loopback Control Multiplexer

This block sits between the dual-rail line interface and the framer of a T1/E1 port. It holds a small loopback control register. The register selects how bipolar line data moves between the receive and transmit sides. With no loopback selected, received line data goes to the receive framer and the transmit formatter's data goes to the line.

In framer loopback, the receive framer is fed from the transmit formatter instead of the line. In T1 operation the line then carries an unframed all-ones signal. In E1 operation the line keeps carrying normal transmit data. In remote loopback, the received line signal is sent straight back out to the line, and the transmit formatter's data is discarded. The receive framer keeps getting the incoming line data in this mode.

The whole block runs on one system clock. Each data path is registered on a bit-enable strobe instead of a clock. Switching the timing source of a path means choosing the other strobe. The block also emits a one-cycle strobe beside each output pair, so the consumer of that pair knows when it was updated.

Top module: `lbk_route_top`

## Requirements
- R1: The control register sits at address 0x4A and holds five bits: bit 0 framer loopback, bit 1 payload loopback, bit 2 remote loopback, bit 3 local loopback, bit 4 line-interface control. A write at 0x4A stores wdata[4:0] at the clock edge. A read at 0x4A returns the stored bits, with bits 7 to 5 as 0. A read at any other address returns 0, and a write at any other address leaves the register unchanged.
- R2: After reset the register, every rail output and both strobe outputs are 0. With bits 0 and 2 clear, a cycle with tx_bit_en high loads fmt_tx_pos/neg into line_tx_pos/neg. line_tx_en is high in the following cycle only.
- R3: With bit 0 clear, or with bit 2 set, a cycle with rx_bit_en high loads line_rx_pos/neg into frm_rx_pos/neg. frm_rx_en is high in the following cycle only.
- R4: With bit 0 set and bit 2 clear, a cycle with tx_bit_en high loads fmt_tx_pos/neg into frm_rx_pos/neg, and frm_rx_en follows tx_bit_en one cycle later. line_rx_pos/neg and rx_bit_en have no effect on the receive outputs.
- R5: With bit 0 set, bit 2 clear and t1_mode high, each tx_bit_en cycle puts one mark on exactly one transmit rail. The marks alternate, and the first mark after entering this state is on the positive rail. fmt_tx is ignored. With t1_mode low, the transmit outputs behave as in R2.
- R6: With bit 2 set, a cycle with rx_bit_en high loads line_rx_pos/neg into line_tx_pos/neg, and line_tx_en follows rx_bit_en. fmt_tx_pos/neg and tx_bit_en have no effect on the transmit outputs.
- R7: When bits 0 and 2 are both set, remote loopback wins: the transmit side follows R6 and the receive side follows R3.
- R8: Bits 1, 3 and 4 have no effect on any data or strobe output. Every rail output holds its value in cycles where its selected strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| t1_mode | input | 1 | Line mode strap: 1 = T1, 0 = E1 |
| rx_bit_en | input | 1 | Receive bit-enable strobe (recovered timing) |
| tx_bit_en | input | 1 | Transmit bit-enable strobe (transmit timing) |
| line_rx_pos | input | 1 | Receive line, positive rail |
| line_rx_neg | input | 1 | Receive line, negative rail |
| fmt_tx_pos | input | 1 | Transmit formatter output, positive rail |
| fmt_tx_neg | input | 1 | Transmit formatter output, negative rail |
| line_tx_pos | output | 1 | Transmit line, positive rail |
| line_tx_neg | output | 1 | Transmit line, negative rail |
| line_tx_en | output | 1 | Pulse marking an update of the transmit line rails |
| frm_rx_pos | output | 1 | Receive framer input, positive rail |
| frm_rx_neg | output | 1 | Receive framer input, negative rail |
| frm_rx_en | output | 1 | Pulse marking an update of the receive framer rails |

## Verification
The assertions assume the bit-enable strobes, rails, strap and register port are synchronous to clk and settled at its edge. The strobes may be high in any cycle, together or apart. Any register value is legal. The properties compare each output one cycle after a strobe against the source that the register and strap select at that edge. The stimulus changes inputs only on the falling edge and draws strobes, rails, strap flips and register writes at random, including values with both loopback bits set and writes to other addresses. The strap changes only rarely, so long runs of T1 all-ones output are exercised.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    // Routing state derived from the control register
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_FRAMER = 2'd1,
        MODE_REMOTE = 2'd2
    } lbk_mode_e;

    // One dual-rail bipolar symbol
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    localparam rail_t RAIL_IDLE = '{pos: 1'b0, neg: 1'b0};

endpackage

// File: rtl/lbk_ctrl_reg.sv
module lbk_ctrl_reg #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CTRL_W    = 5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h4A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CTRL_W-1:0] ctrl
);
    localparam int unsigned PAD_W = DATA_W - CTRL_W;

    typedef struct packed {
        logic [CTRL_W-1:0] bits;
    } reg_state_t;

    reg_state_t state_d, state_q;
    logic       hit;

    always_comb begin
        hit     = (addr == CTRL_ADDR);
        state_d = state_q;
        if (we && hit) begin
            state_d.bits = wdata[CTRL_W-1:0];
        end
        rdata = hit ? {{PAD_W{1'b0}}, state_q.bits} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl = state_q.bits;

endmodule

// File: rtl/lbk_mode_dec.sv
module lbk_mode_dec
    import lbk_pkg::*;
#(
    parameter int unsigned CTRL_W  = 5,
    parameter int unsigned FLB_BIT = 0,
    parameter int unsigned RLB_BIT = 2
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              t1_mode,
    output lbk_mode_e         mode,
    output logic              ais_en
);
    always_comb begin
        if (ctrl[RLB_BIT]) begin
            mode = MODE_REMOTE;
        end else if (ctrl[FLB_BIT]) begin
            mode = MODE_FRAMER;
        end else begin
            mode = MODE_NORMAL;
        end
        ais_en = (mode == MODE_FRAMER) && t1_mode;
    end
endmodule

// File: rtl/lbk_rx_path.sv
module lbk_rx_path
    import lbk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lbk_mode_e mode,
    input  logic      rx_bit_en,
    input  logic      tx_bit_en,
    input  rail_t     line_rx,
    input  rail_t     fmt_tx,
    output rail_t     frm_rx,
    output logic      frm_rx_en
);
    typedef struct packed {
        rail_t data;
        logic  strobe;
    } rx_state_t;

    rx_state_t state_d, state_q;
    logic      sel_tx;
    logic      take;
    rail_t     src;

    always_comb begin
        sel_tx  = (mode == MODE_FRAMER);
        take    = sel_tx ? tx_bit_en : rx_bit_en;
        src     = sel_tx ? fmt_tx : line_rx;
        state_d = state_q;
        state_d.strobe = take;
        if (take) begin
            state_d.data = src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign frm_rx    = state_q.data;
    assign frm_rx_en = state_q.strobe;
endmodule

// File: rtl/lbk_tx_path.sv
module lbk_tx_path
    import lbk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lbk_mode_e mode,
    input  logic      ais_en,
    input  logic      rx_bit_en,
    input  logic      tx_bit_en,
    input  rail_t     line_rx,
    input  rail_t     fmt_tx,
    output rail_t     line_tx,
    output logic      line_tx_en
);
    typedef struct packed {
        rail_t data;
        logic  strobe;
        logic  phase;   // 0: next mark on positive rail
    } tx_state_t;

    tx_state_t state_d, state_q;
    logic      take;
    rail_t     src;
    rail_t     mark;

    always_comb begin
        mark.pos = ~state_q.phase;
        mark.neg =  state_q.phase;
        if (mode == MODE_REMOTE) begin
            take = rx_bit_en;
            src  = line_rx;
        end else if (ais_en) begin
            take = tx_bit_en;
            src  = mark;
        end else begin
            take = tx_bit_en;
            src  = fmt_tx;
        end

        state_d        = state_q;
        state_d.strobe = take;
        if (take) begin
            state_d.data = src;
        end
        if (!ais_en || mode == MODE_REMOTE) begin
            state_d.phase = 1'b0;
        end else if (tx_bit_en) begin
            state_d.phase = ~state_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign line_tx    = state_q.data;
    assign line_tx_en = state_q.strobe;
endmodule

// File: rtl/lbk_route_top.sv
module lbk_route_top
    import lbk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CTRL_W    = 5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h4A,
    parameter int unsigned FLB_BIT   = 0,
    parameter int unsigned RLB_BIT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              t1_mode,
    input  logic              rx_bit_en,
    input  logic              tx_bit_en,
    input  logic              line_rx_pos,
    input  logic              line_rx_neg,
    input  logic              fmt_tx_pos,
    input  logic              fmt_tx_neg,
    output logic              line_tx_pos,
    output logic              line_tx_neg,
    output logic              line_tx_en,
    output logic              frm_rx_pos,
    output logic              frm_rx_neg,
    output logic              frm_rx_en
);
    logic [CTRL_W-1:0] ctrl_q;
    lbk_mode_e         mode;
    logic              ais_en;
    rail_t             line_rx, fmt_tx, line_tx, frm_rx;

    assign line_rx = '{pos: line_rx_pos, neg: line_rx_neg};
    assign fmt_tx  = '{pos: fmt_tx_pos,  neg: fmt_tx_neg};

    lbk_ctrl_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl_q)
    );

    lbk_mode_dec #(
        .CTRL_W(CTRL_W), .FLB_BIT(FLB_BIT), .RLB_BIT(RLB_BIT)
    ) u_dec (
        .ctrl(ctrl_q), .t1_mode(t1_mode), .mode(mode), .ais_en(ais_en)
    );

    lbk_rx_path u_rx (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en),
        .line_rx(line_rx), .fmt_tx(fmt_tx),
        .frm_rx(frm_rx), .frm_rx_en(frm_rx_en)
    );

    lbk_tx_path u_tx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ais_en(ais_en),
        .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en),
        .line_rx(line_rx), .fmt_tx(fmt_tx),
        .line_tx(line_tx), .line_tx_en(line_tx_en)
    );

    assign line_tx_pos = line_tx.pos;
    assign line_tx_neg = line_tx.neg;
    assign frm_rx_pos  = frm_rx.pos;
    assign frm_rx_neg  = frm_rx.neg;

endmodule

// File: rtl/lbk_route_chk.sv
module lbk_route_chk #(
    parameter int unsigned CTRL_W  = 5,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned FLB_BIT = 0,
    parameter int unsigned RLB_BIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              t1_mode,
    input logic              rx_bit_en,
    input logic              tx_bit_en,
    input logic              line_rx_pos,
    input logic              line_rx_neg,
    input logic              fmt_tx_pos,
    input logic              fmt_tx_neg,
    input logic              line_tx_pos,
    input logic              line_tx_neg,
    input logic              line_tx_en,
    input logic              frm_rx_pos,
    input logic              frm_rx_neg,
    input logic              frm_rx_en
);
    logic flb, rlb;
    assign flb = ctrl[FLB_BIT] && !ctrl[RLB_BIT];
    assign rlb = ctrl[RLB_BIT];

    always_comb begin
        if (rst_n) begin
            AST_RDATA_PAD_ZERO: assert (reg_rdata[DATA_W-1:CTRL_W] == '0); // R1
        end
    end

    AST_NORMAL_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (!flb && !rlb && tx_bit_en) |=>
        (line_tx_pos == $past(fmt_tx_pos) && line_tx_neg == $past(fmt_tx_neg) && line_tx_en)); // R2

    AST_RX_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flb && rx_bit_en) |=>
        (frm_rx_pos == $past(line_rx_pos) && frm_rx_neg == $past(line_rx_neg) && frm_rx_en)); // R3

    AST_FLB_RX_FROM_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (flb && tx_bit_en) |=>
        (frm_rx_pos == $past(fmt_tx_pos) && frm_rx_neg == $past(fmt_tx_neg) && frm_rx_en)); // R4

    AST_FLB_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flb && !tx_bit_en) |=> ($stable(frm_rx_pos) && $stable(frm_rx_neg) && !frm_rx_en)); // R4

    AST_AIS_ONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (flb && t1_mode && tx_bit_en) |=> (line_tx_pos != line_tx_neg)); // R5

    AST_RLB_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (rlb && rx_bit_en) |=>
        (line_tx_pos == $past(line_rx_pos) && line_tx_neg == $past(line_rx_neg) && line_tx_en)); // R6

    AST_RLB_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rlb && !rx_bit_en) |=> ($stable(line_tx_pos) && $stable(line_tx_neg) && !line_tx_en)); // R7

endmodule

bind lbk_route_top lbk_route_chk #(
    .CTRL_W(CTRL_W), .DATA_W(DATA_W), .FLB_BIT(FLB_BIT), .RLB_BIT(RLB_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .reg_rdata(reg_rdata),
    .t1_mode(t1_mode), .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en),
    .line_rx_pos(line_rx_pos), .line_rx_neg(line_rx_neg),
    .fmt_tx_pos(fmt_tx_pos), .fmt_tx_neg(fmt_tx_neg),
    .line_tx_pos(line_tx_pos), .line_tx_neg(line_tx_neg), .line_tx_en(line_tx_en),
    .frm_rx_pos(frm_rx_pos), .frm_rx_neg(frm_rx_neg), .frm_rx_en(frm_rx_en)
);

// File: tb/lbk_route_top_test.sv
module lbk_route_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       t1_mode = 1'b1;
    logic       rx_bit_en = 1'b0, tx_bit_en = 1'b0;
    logic       line_rx_pos = 1'b0, line_rx_neg = 1'b0;
    logic       fmt_tx_pos = 1'b0, fmt_tx_neg = 1'b0;
    logic       line_tx_pos, line_tx_neg, line_tx_en;
    logic       frm_rx_pos, frm_rx_neg, frm_rx_en;

    int vectors = 0;
    int errors  = 0;

    // bench model
    logic [4:0] m_ctrl;
    logic [2:0] m_ltx;    // {pos, neg, en}
    logic [2:0] m_frx;
    logic       m_phase;

    lbk_route_top uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .t1_mode(t1_mode),
        .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en),
        .line_rx_pos(line_rx_pos), .line_rx_neg(line_rx_neg),
        .fmt_tx_pos(fmt_tx_pos), .fmt_tx_neg(fmt_tx_neg),
        .line_tx_pos(line_tx_pos), .line_tx_neg(line_tx_neg), .line_tx_en(line_tx_en),
        .frm_rx_pos(frm_rx_pos), .frm_rx_neg(frm_rx_neg), .frm_rx_en(frm_rx_en)
    );

    always #10 clk = ~clk;

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    function automatic string req_tag(input logic [4:0] c, input logic t1);
        if (c[2] && c[0]) return "R7";
        if (c[2])         return "R6";
        if (c[0])         return t1 ? "R5" : "R4";
        if (c[1] || c[3] || c[4]) return "R8";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Advance model by one clock edge using the inputs currently applied
    task automatic model_step();
        logic rlb, flb, ais;
        rlb = m_ctrl[2];
        flb = m_ctrl[0] && !rlb;
        ais = flb && t1_mode;
        // receive side
        if (flb) begin
            m_frx[0] = tx_bit_en;
            if (tx_bit_en) m_frx[2:1] = {fmt_tx_pos, fmt_tx_neg};
        end else begin
            m_frx[0] = rx_bit_en;
            if (rx_bit_en) m_frx[2:1] = {line_rx_pos, line_rx_neg};
        end
        // transmit side
        if (rlb) begin
            m_ltx[0] = rx_bit_en;
            if (rx_bit_en) m_ltx[2:1] = {line_rx_pos, line_rx_neg};
        end else if (ais) begin
            m_ltx[0] = tx_bit_en;
            if (tx_bit_en) m_ltx[2:1] = {~m_phase, m_phase};
        end else begin
            m_ltx[0] = tx_bit_en;
            if (tx_bit_en) m_ltx[2:1] = {fmt_tx_pos, fmt_tx_neg};
        end
        if (!ais) m_phase = 1'b0;
        else if (tx_bit_en) m_phase = ~m_phase;
        if (reg_we && reg_addr == 8'h4A) m_ctrl = reg_wdata[4:0];
    endtask

    task automatic cycle_and_check();
        string tag;
        tag = req_tag(m_ctrl, t1_mode);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, {5'b0, line_tx_pos, line_tx_neg, line_tx_en}, {5'b0, m_ltx});
        check(tag, {5'b0, frm_rx_pos, frm_rx_neg, frm_rx_en},   {5'b0, m_frx});
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        rx_bit_en = 1'b0; tx_bit_en = 1'b0;
        cycle_and_check();
        reg_we = 1'b0;
    endtask

    task automatic drive(input logic rxe, input logic txe, input logic [3:0] rails);
        rx_bit_en = rxe; tx_bit_en = txe;
        {line_rx_pos, line_rx_neg, fmt_tx_pos, fmt_tx_neg} = rails;
        cycle_and_check();
    endtask

    initial begin
        void'($urandom(32'h1D5A_0C47));
        m_ctrl = '0; m_ltx = '0; m_frx = '0; m_phase = 1'b0;
        #35;
        @(negedge clk);
        // R2 reset state
        check("R2", {2'b0, line_tx_pos, line_tx_neg, line_tx_en, frm_rx_pos, frm_rx_neg, frm_rx_en}, 8'h00);
        rst_n = 1'b1;
        reg_addr = 8'h4A;
        #1 check("R1", reg_rdata, 8'h00);

        // R1 register access
        write_reg(8'h4A, 8'hFF);
        reg_addr = 8'h4A; #1 check("R1", reg_rdata, 8'h1F);
        write_reg(8'h4B, 8'h00);
        reg_addr = 8'h4A; #1 check("R1", reg_rdata, 8'h1F);
        reg_addr = 8'h49; #1 check("R1", reg_rdata, 8'h00);
        write_reg(8'h4A, 8'h00);

        // R2/R3 normal directed
        drive(1'b1, 1'b1, 4'b1001);
        drive(1'b0, 1'b0, 4'b0110);          // R8 hold
        // R5 T1 all-ones: marks alternate starting positive
        t1_mode = 1'b1;
        write_reg(8'h4A, 8'h01);
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 4'b1100);
        // R4 E1 framer loopback
        t1_mode = 1'b0;
        drive(1'b1, 1'b1, 4'b0110);
        drive(1'b1, 1'b0, 4'b1001);          // rx ignored
        // R7 both bits set
        write_reg(8'h4A, 8'h05);
        drive(1'b1, 1'b0, 4'b1000);
        drive(1'b0, 1'b1, 4'b0101);
        // R8 unused control bits only
        write_reg(8'h4A, 8'h1A);
        drive(1'b1, 1'b1, 4'b0110);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 31) == 0) begin
                write_reg(($urandom_range(0, 7) == 0) ? 8'h4C : 8'h4A, 8'($urandom()));
                reg_addr = 8'h4A;
                #1 check("R1", reg_rdata, {3'b0, m_ctrl});
            end
            if ($urandom_range(0, 199) == 0) t1_mode = ~t1_mode;
            drive(1'($urandom()), 1'($urandom()), 4'($urandom()));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule